// File: doc/BRIEF.md
# Time-Multiplexed Serial Link Framer

The framer gathers 32-bit words from eighteen front-end channels and sends them on one serial line as an endless train of fixed frames. Each channel writes into its own four-word buffer on its own capture clock. The buffer carries the word across to the link clock through gray-coded pointers. On the link side a sequencer builds frames of nineteen word slots. The first slot holds a reserved separator pattern. Slots one to eighteen belong to channels 0 to 17 in ascending order. The owner of a slot follows from its position alone, so no slot carries a channel header.

Every slot goes out as 35 serial bits, most significant first. The bits are a start bit of 1, the 32 data bits with the MSB first, an even-parity bit, and a stop bit of 0. A channel whose buffer is empty when its slot begins sends a data field of all zeros. Each channel gives up at most one word per frame, and its words leave in the order they were written. A full buffer raises a back-pressure flag on the capture side. Any write offered while the buffer is full is dropped.

Top module: `lf_link_framer`

## Requirements
- R1: While reset is held, `link_bit`, `frame_sync` and every `cap_full` bit are 0.
- R2: Every slot lasts exactly 35 link clocks. Its first bit is 1 (start) and its last bit is 0 (stop).
- R3: Bits 2 to 33 of a slot carry the 32-bit data word, most significant bit first.
- R4: Bit 34 of a slot is the XOR of its 32 data bits, which gives even parity.
- R5: A frame holds 19 slots in a fixed order: the separator, then channel 0, then channel 1, up to channel 17. The first frame begins on the first link clock after reset is released.
- R6: The data field of the separator slot equals the parameter `SEP_WORD`.
- R7: When a channel has no buffered word as its slot begins, that slot carries an all-zero data field with a parity bit of 0.
- R8: A channel sends at most one word per frame. Its words come out in the order it wrote them.
- R9: `frame_sync` is 1 for exactly the first bit period of each separator slot and is 0 at every other time.
- R10: Each channel buffer holds 4 words. `cap_full` rises once 4 words wait in the buffer. A write offered while `cap_full` is 1 is dropped and never shows up on the link.
- R11: A word written on a channel's own capture clock, running at any rate, reaches the link unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| link_clk | input | 1 | Link bit clock |
| link_rst_n | input | 1 | Active-low asynchronous reset, link side |
| cap_clk | input | NUM_CH | One capture clock per channel |
| cap_rst_n | input | 1 | Active-low asynchronous reset, capture side |
| cap_valid | input | NUM_CH | Write request per channel |
| cap_data | input | NUM_CH*DATA_W | Write data; channel c uses bits [c*DATA_W +: DATA_W] |
| cap_full | output | NUM_CH | Buffer full per channel, in that channel's capture domain |
| link_bit | output | 1 | Serial output bit |
| frame_sync | output | 1 | High during the first bit of each separator slot |

## Verification
The framer has no status path, so every internal fault has to show up in the serial stream. A slot or bit counter that is off by one makes the start or stop bit land on the wrong link clock, and the bit-by-bit comparison catches this within one slot of 35 clocks. A read pointer in a buffer that skips, repeats or runs past the write pointer sends a wrong or stale word in that channel's slot. This shows up within one frame of 665 clocks. A full flag that is computed wrong either accepts a fifth word or stalls the writer. Both errors appear in the frames that follow, when the backlog drains.

// File: rtl/lf_pkg.sv
package lf_pkg;
    localparam int unsigned LF_NUM_CH = 18;
    localparam int unsigned LF_DATA_W = 32;
    localparam int unsigned LF_DEPTH  = 4;
    localparam logic [LF_DATA_W-1:0] LF_SEP_DEFAULT = 32'hA5C3_0F96;

    function automatic logic [7:0] lf_bin2gray(input logic [7:0] b);
        return b ^ (b >> 1);
    endfunction
endpackage

// File: rtl/lf_cdc_fifo.sv
module lf_cdc_fifo #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_pop,
    output logic              rd_empty,
    output logic [DATA_W-1:0] rd_data
);
    import lf_pkg::*;
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic [PW-1:0] s1;
        logic [PW-1:0] s2;
    } side_t;

    side_t wr_d, wr_q, rd_d, rd_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic wr_en;

    assign wr_full  = (wr_q.gray == {~wr_q.s2[PW-1:PW-2], wr_q.s2[PW-3:0]});
    assign wr_en    = wr_valid && !wr_full;
    assign rd_empty = (rd_q.gray == rd_q.s2);
    assign rd_data  = mem[rd_q.bin[AW-1:0]];

    always_comb begin
        logic [PW-1:0] nb;
        wr_d    = wr_q;
        nb      = wr_q.bin + PW'(wr_en);
        wr_d.bin  = nb;
        wr_d.gray = PW'(lf_bin2gray(8'(nb)));
        wr_d.s1   = rd_q.gray;
        wr_d.s2   = wr_q.s1;
    end

    always_comb begin
        logic [PW-1:0] nb;
        rd_d    = rd_q;
        nb      = rd_q.bin + PW'(rd_pop && !rd_empty);
        rd_d.bin  = nb;
        rd_d.gray = PW'(lf_bin2gray(8'(nb)));
        rd_d.s1   = wr_q.gray;
        rd_d.s2   = rd_q.s1;
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) wr_q <= '0;
        else           wr_q <= wr_d;
    end

    always_ff @(posedge wr_clk) begin
        if (wr_en) mem[wr_q.bin[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) rd_q <= '0;
        else           rd_q <= rd_d;
    end

    // R10: a refused write leaves the write pointer where it was
    a_r10_no_overflow: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_valid && wr_full) |=> $stable(wr_q.bin));

    // R8: the sequencer never pops an empty buffer
    a_r8_no_underflow: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_pop |-> !rd_empty);
endmodule

// File: rtl/lf_frame_seq.sv
module lf_frame_seq #(
    parameter int unsigned NUM_CH = 18,
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] SEP_WORD = 32'hA5C3_0F96
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CH-1:0]              ch_empty,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  ch_data,
    output logic [NUM_CH-1:0]              ch_pop,
    output logic                           link_bit,
    output logic                           frame_sync
);
    localparam int unsigned FRAME_W = DATA_W + 3;
    localparam int unsigned BIT_W   = $clog2(FRAME_W);
    localparam int unsigned SLOT_N  = NUM_CH + 1;
    localparam int unsigned SLOT_W  = $clog2(SLOT_N);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(FRAME_W - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOT_N - 1);

    typedef struct packed {
        logic               active;
        logic [SLOT_W-1:0]  slot;
        logic [BIT_W-1:0]   bitn;
        logic [FRAME_W-1:0] shreg;
    } seq_t;

    seq_t state_d, state_q;

    always_comb begin
        logic              load;
        logic [SLOT_W-1:0] nslot;
        logic [DATA_W-1:0] word;
        state_d = state_q;
        ch_pop  = '0;
        word    = '0;
        nslot   = '0;
        load    = !state_q.active || (state_q.bitn == LAST_BIT);
        if (load) begin
            if (state_q.active && state_q.slot != LAST_SLOT)
                nslot = state_q.slot + 1'b1;
            if (nslot == '0) begin
                word = SEP_WORD;
            end else begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (nslot == SLOT_W'(c + 1) && !ch_empty[c]) begin
                        word      = ch_data[c];
                        ch_pop[c] = 1'b1;
                    end
                end
            end
            state_d.active = 1'b1;
            state_d.slot   = nslot;
            state_d.bitn   = '0;
            state_d.shreg  = {1'b1, word, ^word, 1'b0};
        end else begin
            state_d.bitn  = state_q.bitn + 1'b1;
            state_d.shreg = state_q.shreg << 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign link_bit   = state_q.shreg[FRAME_W-1];
    assign frame_sync = state_q.active && (state_q.slot == '0) && (state_q.bitn == '0);

    // R2: the bit after a stop bit is the next start bit
    a_r2_start_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.active && state_q.bitn == LAST_BIT) |=> link_bit);
    // R2: the last bit of a slot is the stop bit
    a_r2_stop_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.active && state_q.bitn == LAST_BIT) |-> !link_bit);
    // R5: the slot after channel 17 is the separator
    a_r5_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.active && state_q.bitn == LAST_BIT && state_q.slot == LAST_SLOT) |=> (state_q.slot == '0));
    // R8: no more than one channel is served per load
    a_r8_one_pop: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ch_pop));
    // R9: the frame marker lasts a single bit period
    a_r9_sync_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> !frame_sync);
endmodule

// File: rtl/lf_link_framer.sv
module lf_link_framer #(
    parameter int unsigned NUM_CH = lf_pkg::LF_NUM_CH,
    parameter int unsigned DATA_W = lf_pkg::LF_DATA_W,
    parameter int unsigned DEPTH  = lf_pkg::LF_DEPTH,
    parameter logic [DATA_W-1:0] SEP_WORD = lf_pkg::LF_SEP_DEFAULT
) (
    input  logic                     link_clk,
    input  logic                     link_rst_n,
    input  logic [NUM_CH-1:0]        cap_clk,
    input  logic                     cap_rst_n,
    input  logic [NUM_CH-1:0]        cap_valid,
    input  logic [NUM_CH*DATA_W-1:0] cap_data,
    output logic [NUM_CH-1:0]        cap_full,
    output logic                     link_bit,
    output logic                     frame_sync
);
    logic [NUM_CH-1:0]             ch_empty;
    logic [NUM_CH-1:0]             ch_pop;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_data;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        lf_cdc_fifo #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_fifo (
            .wr_clk   (cap_clk[g]),
            .wr_rst_n (cap_rst_n),
            .wr_valid (cap_valid[g]),
            .wr_data  (cap_data[g*DATA_W +: DATA_W]),
            .wr_full  (cap_full[g]),
            .rd_clk   (link_clk),
            .rd_rst_n (link_rst_n),
            .rd_pop   (ch_pop[g]),
            .rd_empty (ch_empty[g]),
            .rd_data  (ch_data[g])
        );
    end

    lf_frame_seq #(
        .NUM_CH   (NUM_CH),
        .DATA_W   (DATA_W),
        .SEP_WORD (SEP_WORD)
    ) u_seq (
        .clk        (link_clk),
        .rst_n      (link_rst_n),
        .ch_empty   (ch_empty),
        .ch_data    (ch_data),
        .ch_pop     (ch_pop),
        .link_bit   (link_bit),
        .frame_sync (frame_sync)
    );
endmodule

// File: tb/lf_link_framer_tb_top.sv
module lf_link_framer_tb_top;
    localparam int NUM_CH = 18;
    localparam int DATA_W = 32;
    localparam logic [31:0] SEP = 32'hA5C3_0F96;

    logic link_clk = 1'b0;
    logic link_rst_n = 1'b0;
    logic cap_rst_n = 1'b0;
    logic [NUM_CH-1:0] cap_clk = '0;
    logic [NUM_CH-1:0] cap_valid;
    logic [NUM_CH*DATA_W-1:0] cap_data;
    logic [NUM_CH-1:0] cap_full;
    logic link_bit, frame_sync;

    logic [31:0] drv_d [NUM_CH];
    logic        drv_v [NUM_CH];
    int          pend  [NUM_CH];
    bit          force_w [NUM_CH];
    logic [31:0] mq [NUM_CH][$];

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 link_clk = ~link_clk;

    lf_link_framer dut_i (
        .link_clk(link_clk), .link_rst_n(link_rst_n), .cap_clk(cap_clk),
        .cap_rst_n(cap_rst_n), .cap_valid(cap_valid), .cap_data(cap_data),
        .cap_full(cap_full), .link_bit(link_bit), .frame_sync(frame_sync)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // R11: each channel runs its own capture clock and writer
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cap
        int   seq_n = 1;
        logic full_seen = 1'b0;
        assign cap_valid[g] = drv_v[g];
        assign cap_data[g*DATA_W +: DATA_W] = drv_d[g];
        initial begin
            drv_v[g] = 1'b0;
            drv_d[g] = '0;
            pend[g] = 0;
            force_w[g] = 0;
            forever #(10 + (g % 4)) cap_clk[g] = ~cap_clk[g];
        end
        always @(negedge cap_clk[g]) begin
            if (drv_v[g] === 1'b1) begin
                if (!full_seen) begin
                    mq[g].push_back(drv_d[g]);
                    seq_n++;
                end
                pend[g]--;
            end
            if (pend[g] > 0 && cap_rst_n && (force_w[g] || !cap_full[g])) begin
                drv_v[g] = 1'b1;
                drv_d[g] = {8'(g + 1), 24'(seq_n)};
                full_seen = cap_full[g];
            end else begin
                drv_v[g] = 1'b0;
            end
        end
    end

    initial begin
        int cyc = 0;
        while (cyc < 20000) begin
            @(posedge link_clk);
            cyc++;
        end
        chk(0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        int frame = -1;
        int slot = 18;
        int bitp = 34;
        logic [34:0] cur = '0;
        string tag = "";
        repeat (5) @(negedge link_clk);
        // R1: reset state
        chk(link_bit == 1'b0, "R1 link_bit", link_bit, 0);
        chk(frame_sync == 1'b0, "R1 frame_sync", frame_sync, 0);
        chk(cap_full == '0, "R1 cap_full", cap_full, 0);
        cap_rst_n = 1'b1;
        @(negedge link_clk);
        link_rst_n = 1'b1;
        forever begin
            @(negedge link_clk);
            if (bitp == 34) begin
                logic [31:0] w;
                bitp = 0;
                slot = (slot == 18) ? 0 : slot + 1;
                if (slot == 0) begin
                    frame++;
                    w = SEP;
                    tag = "R6";
                    if (frame == 1) for (int c = 0; c < NUM_CH; c++) pend[c] = 1;
                    if (frame == 2) for (int c = 0; c < NUM_CH; c += 2) pend[c] = 2;
                    if (frame == 4) begin force_w[17] = 1; pend[17] = 6; end
                    if (frame == 10) begin
                        // R10: all buffers drained, no full flag left
                        chk(cap_full == '0, "R10 drained", cap_full, 0);
                        finish_run();
                    end
                end else if (mq[slot-1].size() > 0) begin
                    w = mq[slot-1].pop_front();
                    tag = "R3 R5 R8 R11";
                end else begin
                    w = '0;
                    tag = "R7";
                end
                cur = {1'b1, w, ^w, 1'b0};
            end else begin
                bitp++;
            end
            if (frame == 4 && slot == 10 && bitp == 0) begin
                // R10: four accepted writes fill channel 17, neighbour unaffected
                chk(cap_full[17] == 1'b1, "R10 full", cap_full[17], 1);
                chk(cap_full[16] == 1'b0, "R10 not full", cap_full[16], 0);
            end
            if (bitp == 0 || bitp == 34)
                chk(link_bit == cur[34-bitp], "R2 framing bit", link_bit, cur[34-bitp]);
            else if (bitp == 33)
                chk(link_bit == cur[34-bitp], "R4 parity", link_bit, cur[34-bitp]);
            else
                chk(link_bit == cur[34-bitp], tag, link_bit, cur[34-bitp]);
            chk(frame_sync == (slot == 0 && bitp == 0), "R9 frame_sync",
                frame_sync, (slot == 0 && bitp == 0));
        end
    end
endmodule